// File: doc/BRIEF.md
# Ping-Pong Frame Capture Controller

This block sits between a camera that delivers two bytes per pixel and a block-matching motion engine. It keeps only the luma byte, which is the second byte of each pixel, and writes it into one of two frame stores. The two stores trade roles at the start of every frame. Once a frame has ended, the engine pulls pixel pairs out of both stores at once. The reference pixel comes from the older frame and the search pixel from the newer one. Each store is a stack of fixed-size single-port banks, and a bank-select field in the upper address bits picks the bank.

The frame stores are single-port, so capture and readout never overlap. Reads are only accepted after frame-valid has been low for a full cycle. The engine moves the search pointer by loading an absolute address into it. A search address whose bank field names a bank that does not exist reaches no memory and raises a sticky error flag. The block also produces a new set of framing signals for the downstream buffer that stores motion-vector results: an output frame-valid and line-valid that are high while no frame is being captured, and one output pixel-clock pulse for every motion vector the engine latches.

All sizes are parameters. The frame size, the bank depth and the width of the bank field set the address layout. For a 352x288 frame, the settings are 14 word bits and a 3-bit bank field, which gives seven banks in use out of eight codes.

Top module: `fcap_pingpong`

## Requirements
- R1: A byte is written only in a cycle where fv_in, lv_in and the byte phase all mark it as luma. In that cycle the receiving stack has stk_ce_n=0 and stk_we_n=0, and the byte lands at the current write address.
- R2: Inside each run of lv_in high, bytes alternate between ignored and luma, and the first byte of the run is ignored. At most one byte is written in any two consecutive cycles, and ignored bytes never reach memory.
- R3: While lv_in is low, both stacks hold stk_ce_n=1 during capture. The write address holds, so the next line continues at the next pixel index.
- R4: The first frame after reset goes to stack 0. Every rising edge of fv_in hands the write role to the other stack and restarts the write address at 0.
- R5: rd_req is acted on only when fv_in is low in the current cycle and was low in the previous cycle. At any other time it causes no strobe and no rd_valid.
- R6: An accepted read drives stk_ce_n=0 and stk_we_n=1 on both stacks. One cycle later rd_valid=1, and the outputs carry ref_pix from the stack written before the latest one and srch_pix from the latest one.
- R7: The reference and search read counters return to 0 on each falling edge of fv_in. Each accepted read advances them by one, and they step from PIX-1 (PIX = FRAME_W*FRAME_H) back to 0.
- R8: A one-cycle srch_ld pulse loads srch_ld_addr into the search counter. The next accepted read uses that address, and the reference counter is left untouched.
- R9: An address splits into bank = addr[BANK_AW+FIELD_W-1:BANK_AW] and word = addr[BANK_AW-1:0], and the banks in use are those below ceil(PIX/2^BANK_AW). A read whose search bank is out of range leaves the search stack at stk_ce_n=1, returns srch_pix=0, and sets err_bank, which stays set until reset.
- R10: fv_out is the inverse of fv_in delayed by one cycle, and lv_out always equals fv_out.
- R11: pclk_out is high for exactly the cycle after each cycle in which mv_done is high.
- R12: During reset, stk_ce_n=2'b11, rd_valid=0, err_bank=0, fv_out=0 and pclk_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_byte | input | 8 | Camera byte stream, two bytes per pixel |
| fv_in | input | 1 | Incoming frame-valid |
| lv_in | input | 1 | Incoming line-valid |
| rd_req | input | 1 | Engine requests one reference/search pixel pair |
| srch_ld | input | 1 | Load the search counter |
| srch_ld_addr | input | BANK_AW+FIELD_W | Value loaded into the search counter |
| mv_done | input | 1 | Engine has latched a motion vector |
| ref_pix | output | 8 | Reference (older frame) pixel |
| srch_pix | output | 8 | Search (newer frame) pixel |
| rd_valid | output | 1 | ref_pix/srch_pix valid this cycle |
| stk_ce_n | output | 2 | Per-stack active-low chip enable |
| stk_we_n | output | 2 | Per-stack active-low write enable |
| err_bank | output | 1 | Sticky out-of-range bank flag |
| fv_out | output | 1 | Regenerated frame-valid for the result buffer |
| lv_out | output | 1 | Regenerated line-valid, equal to fv_out |
| pclk_out | output | 1 | One pulse per latched motion vector |

## Verification
The bench fills two frames with pixel values that depend on their index and places line gaps between rows. If a line gap advanced the write address, or if the chroma byte were stored in place of luma, every value read back after the first row would be shifted or wrong. It reads a whole frame and carries on past the last pixel. A counter that failed to wrap would read an address beyond the frame and return the wrong value, and a counter not cleared by the next frame's end would start in the middle of the frame. It then loads an in-range search address and one with bank code 7, and issues a read during capture. An address decoder that let bank 7 through would strobe the search stack, and a read gate that ignored frame-valid would raise rd_valid in the middle of a frame. A third frame shows whether the stacks really swap: without the swap, the reference read would return the frame just captured.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

  // Next read/write address: wraps to zero after the last pixel of a frame,
  // otherwise increments (the caller truncates to the address width).
  function automatic int unsigned next_addr(int unsigned a, int unsigned pix);
    return (a == pix - 1) ? 0 : a + 1;
  endfunction

  // True when the bank field of an address names a populated bank.
  function automatic logic bank_ok(int unsigned a, int unsigned bank_aw,
                                   int unsigned nbanks);
    return (a >> bank_aw) < nbanks;
  endfunction

  // Number of banks needed to hold a frame.
  function automatic int unsigned banks_for(int unsigned pix, int unsigned bank_aw);
    return (pix + (1 << bank_aw) - 1) >> bank_aw;
  endfunction

endpackage

// File: rtl/fcap_bank.sv
module fcap_bank #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/fcap_stack.sv
module fcap_stack #(
  parameter int BANK_AW   = 5,
  parameter int FIELD_W   = 3,
  parameter int NUM_BANKS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_n,
  input  logic                       we_n,
  input  logic [BANK_AW+FIELD_W-1:0] addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata
);
  localparam int ADDR_W = BANK_AW + FIELD_W;

  logic [FIELD_W-1:0]   bank_sel;
  logic [BANK_AW-1:0]   word_addr;
  logic                 sel_ok;
  logic [NUM_BANKS-1:0] bank_en;
  logic [FIELD_W-1:0]   sel_q;
  logic [7:0]           bank_rd [NUM_BANKS];

  assign bank_sel  = addr[ADDR_W-1:BANK_AW];
  assign word_addr = addr[BANK_AW-1:0];
  assign sel_ok    = fcap_pkg::bank_ok(32'(addr), BANK_AW, NUM_BANKS);

  always_comb begin
    bank_en = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      bank_en[i] = !ce_n && sel_ok && (bank_sel == FIELD_W'(i));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fcap_bank #(.AW(BANK_AW)) u_bank (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (!we_n),
      .addr  (word_addr),
      .wdata (wdata),
      .rdata (bank_rd[b])
    );
  end

  // Remember which bank answered the last read.
  always_ff @(posedge clk) begin
    if (!rst_n)                        sel_q <= '0;
    else if (!ce_n && we_n && sel_ok)  sel_q <= bank_sel;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (sel_q == FIELD_W'(i)) rdata = bank_rd[i];
  end

  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en)); // R9
  AST_BAD_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && (32'(bank_sel) >= NUM_BANKS)) |-> (bank_en == '0)); // R9
endmodule

// File: rtl/fcap_writer.sv
module fcap_writer #(
  parameter int ADDR_W = 8,
  parameter int PIX    = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fv_in,
  input  logic              lv_in,
  output logic              fire,
  output logic [ADDR_W-1:0] waddr,
  output logic              wstack
);
  logic fv_q;
  logic phase;     // 0: chroma byte slot, 1: luma byte slot
  logic fv_rise;

  assign fv_rise = fv_in && !fv_q;
  assign fire    = fv_in && lv_in && phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_q   <= 1'b0;
      phase  <= 1'b0;
      waddr  <= '0;
      wstack <= 1'b1;   // first rise hands the write role to stack 0
    end else begin
      fv_q  <= fv_in;
      phase <= (fv_in && lv_in) ? !phase : 1'b0;
      if (fv_rise) begin
        wstack <= !wstack;
        waddr  <= '0;
      end else if (fire) begin
        waddr <= ADDR_W'(fcap_pkg::next_addr(32'(waddr), PIX));
      end
    end
  end

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lv_in && !fv_rise) |=> $stable(waddr)); // R3
  AST_ROLE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    fv_rise |=> (wstack != $past(wstack))); // R4
endmodule

// File: rtl/fcap_reader.sv
module fcap_reader #(
  parameter int ADDR_W    = 8,
  parameter int BANK_AW   = 5,
  parameter int NUM_BANKS = 6,
  parameter int PIX       = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fv_in,
  input  logic              rd_req,
  input  logic              srch_ld,
  input  logic [ADDR_W-1:0] srch_ld_addr,
  output logic              go,
  output logic [ADDR_W-1:0] ref_addr,
  output logic [ADDR_W-1:0] srch_addr,
  output logic              srch_ok,
  output logic              err
);
  logic fv_q;
  logic fv_fall;

  assign fv_fall = !fv_in && fv_q;
  assign go      = rd_req && !fv_in && !fv_q;
  assign srch_ok = fcap_pkg::bank_ok(32'(srch_addr), BANK_AW, NUM_BANKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_q      <= 1'b0;
      ref_addr  <= '0;
      srch_addr <= '0;
      err       <= 1'b0;
    end else begin
      fv_q <= fv_in;
      if (go && !srch_ok) err <= 1'b1;
      if (fv_fall) begin
        ref_addr  <= '0;
        srch_addr <= '0;
      end else begin
        if (go)
          ref_addr <= ADDR_W'(fcap_pkg::next_addr(32'(ref_addr), PIX));
        if (srch_ld)
          srch_addr <= srch_ld_addr;
        else if (go)
          srch_addr <= ADDR_W'(fcap_pkg::next_addr(32'(srch_addr), PIX));
      end
    end
  end

  AST_REF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (32'(ref_addr) == PIX - 1)) |=> (ref_addr == '0)); // R7
  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fv_fall |=> (ref_addr == '0)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
endmodule

// File: rtl/fcap_pingpong.sv
module fcap_pingpong #(
  parameter int FRAME_W = 16,
  parameter int FRAME_H = 12,
  parameter int BANK_AW = 5,
  parameter int FIELD_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [7:0]                 pix_byte,
  input  logic                       fv_in,
  input  logic                       lv_in,
  input  logic                       rd_req,
  input  logic                       srch_ld,
  input  logic [BANK_AW+FIELD_W-1:0] srch_ld_addr,
  input  logic                       mv_done,
  output logic [7:0]                 ref_pix,
  output logic [7:0]                 srch_pix,
  output logic                       rd_valid,
  output logic [1:0]                 stk_ce_n,
  output logic [1:0]                 stk_we_n,
  output logic                       err_bank,
  output logic                       fv_out,
  output logic                       lv_out,
  output logic                       pclk_out
);
  localparam int PIX       = FRAME_W * FRAME_H;
  localparam int ADDR_W    = BANK_AW + FIELD_W;
  localparam int NUM_BANKS = fcap_pkg::banks_for(PIX, BANK_AW);

  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_stack;
  logic              rd_go;
  logic [ADDR_W-1:0] ref_addr;
  logic [ADDR_W-1:0] srch_addr;
  logic              srch_ok;
  logic [ADDR_W-1:0] st_addr [2];
  logic [7:0]        st_rd   [2];
  logic              rsel_q;
  logic              sbad_q;

  fcap_writer #(.ADDR_W(ADDR_W), .PIX(PIX)) u_writer (
    .clk    (clk),
    .rst_n  (rst_n),
    .fv_in  (fv_in),
    .lv_in  (lv_in),
    .fire   (wr_fire),
    .waddr  (wr_addr),
    .wstack (wr_stack)
  );

  fcap_reader #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS),
                .PIX(PIX)) u_reader (
    .clk          (clk),
    .rst_n        (rst_n),
    .fv_in        (fv_in),
    .rd_req       (rd_req),
    .srch_ld      (srch_ld),
    .srch_ld_addr (srch_ld_addr),
    .go           (rd_go),
    .ref_addr     (ref_addr),
    .srch_addr    (srch_addr),
    .srch_ok      (srch_ok),
    .err          (err_bank)
  );

  // The write stack doubles as the search stack once capture ends.
  always_comb begin
    stk_ce_n   = 2'b11;
    stk_we_n   = 2'b11;
    st_addr[0] = ref_addr;
    st_addr[1] = ref_addr;
    stk_ce_n[wr_stack]  = !(wr_fire || (rd_go && srch_ok));
    stk_we_n[wr_stack]  = !wr_fire;
    st_addr[wr_stack]   = wr_fire ? wr_addr : srch_addr;
    stk_ce_n[!wr_stack] = !rd_go;
    st_addr[!wr_stack]  = ref_addr;
  end

  for (genvar s = 0; s < 2; s++) begin : g_stack
    fcap_stack #(.BANK_AW(BANK_AW), .FIELD_W(FIELD_W),
                 .NUM_BANKS(NUM_BANKS)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (stk_ce_n[s]),
      .we_n  (stk_we_n[s]),
      .addr  (st_addr[s]),
      .wdata (pix_byte),
      .rdata (st_rd[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsel_q   <= 1'b0;
      sbad_q   <= 1'b0;
      rd_valid <= 1'b0;
      fv_out   <= 1'b0;
      pclk_out <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) begin
        rsel_q <= wr_stack;
        sbad_q <= !srch_ok;
      end
      fv_out   <= !fv_in;
      pclk_out <= mv_done;
    end
  end

  assign lv_out   = fv_out;
  assign ref_pix  = st_rd[!rsel_q];
  assign srch_pix = sbad_q ? 8'h00 : st_rd[rsel_q];

  AST_FV_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fv_out == !$past(fv_in))); // R10
  AST_PCLK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mv_done |=> pclk_out); // R11
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid); // R6
  AST_REF_IDLE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    fv_in |-> stk_ce_n[!wr_stack]); // R5
endmodule

// File: tb/fcap_pingpong_test.sv
`timescale 1ns/1ps
module fcap_pingpong_test;
  localparam int W = 16;
  localparam int H = 12;
  localparam int PIX = W * H;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pix_byte;
  logic       fv_in, lv_in, rd_req, srch_ld, mv_done;
  logic [7:0] srch_ld_addr;
  logic [7:0] ref_pix, srch_pix;
  logic       rd_valid, err_bank, fv_out, lv_out, pclk_out;
  logic [1:0] stk_ce_n, stk_we_n;

  int checks = 0;
  int errors = 0;
  int ref_i  = 0;
  int srch_i = 0;

  always #4 clk = !clk;

  fcap_pingpong #(.FRAME_W(W), .FRAME_H(H), .BANK_AW(5), .FIELD_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .pix_byte(pix_byte), .fv_in(fv_in), .lv_in(lv_in),
    .rd_req(rd_req), .srch_ld(srch_ld), .srch_ld_addr(srch_ld_addr),
    .mv_done(mv_done), .ref_pix(ref_pix), .srch_pix(srch_pix),
    .rd_valid(rd_valid), .stk_ce_n(stk_ce_n), .stk_we_n(stk_we_n),
    .err_bank(err_bank), .fv_out(fv_out), .lv_out(lv_out), .pclk_out(pclk_out));

  function automatic logic [7:0] lum(int f, int i);
    return 8'((i * 7) + (f * 31) + 5);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends one frame; ws = stack expected to receive it; poke = try a read mid-frame.
  task automatic send_frame(int f, int ws, bit poke);
    @(negedge clk); fv_in = 1'b1; lv_in = 1'b0;
    @(negedge clk);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        lv_in = 1'b1; pix_byte = 8'hA5;
        #1;
        if (r == 0 && c == 0) check("R2 chroma slot idle", 32'(stk_ce_n), 32'h3);
        @(negedge clk); pix_byte = lum(f, r * W + c);
        #1;
        if (r == 0 && c == 0) begin
          check("R1 write ce_n", 32'(stk_ce_n[ws]), 0);
          check("R1 write we_n", 32'(stk_we_n[ws]), 0);
          check("R4 other stack idle", 32'(stk_ce_n[1-ws]), 1);
        end
        @(negedge clk);
      end
      lv_in = 1'b0;
      #1;
      if (r == 0) begin
        check("R3 standby in gap", 32'(stk_ce_n), 32'h3);
        check("R10 fv_out low in frame", 32'(fv_out), 0);
        check("R10 lv_out low in frame", 32'(lv_out), 0);
      end
      if (r == 1 && poke) begin
        rd_req = 1'b1; #1;
        check("R5 no strobe during frame", 32'(stk_ce_n), 32'h3);
        @(negedge clk); rd_req = 1'b0;
        check("R5 no rd_valid during frame", 32'(rd_valid), 0);
      end
      repeat (3) @(negedge clk);
    end
    fv_in = 1'b0;
    repeat (2) @(negedge clk);
    ref_i = 0; srch_i = 0;
  endtask

  task automatic read_one(int rf, int sf, bit strobe_chk, string tag);
    rd_req = 1'b1; #1;
    if (strobe_chk) begin
      check("R6 read ce_n", 32'(stk_ce_n), 0);
      check("R6 read we_n", 32'(stk_we_n), 32'h3);
    end
    @(negedge clk); rd_req = 1'b0;
    check({tag, " rd_valid"}, 32'(rd_valid), 1);
    check({tag, " ref"}, 32'(ref_pix), 32'(lum(rf, ref_i)));
    check({tag, " srch"}, 32'(srch_pix), 32'(lum(sf, srch_i)));
    ref_i  = (ref_i == PIX - 1) ? 0 : ref_i + 1;
    srch_i = (srch_i == PIX - 1) ? 0 : srch_i + 1;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; fv_in = 0; lv_in = 0; rd_req = 0; srch_ld = 0; mv_done = 0;
    pix_byte = 0; srch_ld_addr = 0;
    repeat (3) @(negedge clk);
    check("R12 ce_n", 32'(stk_ce_n), 32'h3);
    check("R12 rd_valid", 32'(rd_valid), 0);
    check("R12 err", 32'(err_bank), 0);
    check("R12 fv_out", 32'(fv_out), 0);
    check("R12 pclk", 32'(pclk_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 fv_out idle", 32'(fv_out), 1);
    check("R10 lv_out idle", 32'(lv_out), 1);
  endtask

  task automatic test_full_read();
    for (int i = 0; i < PIX; i++) read_one(0, 1, i == 0, "R6/R1 seq");
    check("R7 wrapped counter", ref_i, 0);
    read_one(0, 1, 1'b0, "R7 wrap");
  endtask

  task automatic test_load();
    srch_ld = 1'b1; srch_ld_addr = 8'd100;
    @(negedge clk); srch_ld = 1'b0;
    srch_i = 100;
    read_one(0, 1, 1'b0, "R8 load");
  endtask

  task automatic test_bad_bank();
    srch_ld = 1'b1; srch_ld_addr = 8'hE0;   // bank field 7
    @(negedge clk); srch_ld = 1'b0;
    rd_req = 1'b1; #1;
    check("R9 search stack untouched", 32'(stk_ce_n[1]), 1);
    check("R9 ref stack read", 32'(stk_ce_n[0]), 0);
    @(negedge clk); rd_req = 1'b0;
    check("R9 rd_valid", 32'(rd_valid), 1);
    check("R9 srch zero", 32'(srch_pix), 0);
    check("R9 ref ok", 32'(ref_pix), 32'(lum(0, ref_i)));
    check("R9 err set", 32'(err_bank), 1);
    repeat (2) @(negedge clk);
    check("R9 err sticky", 32'(err_bank), 1);
    ref_i++;
  endtask

  task automatic test_third_frame();
    send_frame(2, 0, 1'b1);
    check("R10 fv_out after frame", 32'(fv_out), 1);
    for (int i = 0; i < 4; i++) read_one(1, 2, 1'b0, "R4/R7 swapped");
    check("R9 err still set", 32'(err_bank), 1);
  endtask

  task automatic test_pclk();
    mv_done = 1'b1;
    @(negedge clk); mv_done = 1'b0;
    check("R11 pulse", 32'(pclk_out), 1);
    @(negedge clk);
    check("R11 single", 32'(pclk_out), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    send_frame(0, 0, 1'b0);
    send_frame(1, 1, 1'b0);
    test_full_read();
    test_load();
    test_bad_bank();
    test_third_frame();
    test_pclk();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule